// File: doc/BRIEF.md
# Buck power-stage gate mode controller

This controller sits between a multiphase PWM controller and the gate drivers of one synchronous buck phase. All of its inputs come from comparators and are already digital. Each three-level control input (PWM and SKIP) arrives as a pair of flags: one for "above the high threshold" and one for "below the low threshold". When neither flag is set, or both are, the pin is in its mid (tri-state) window. Two more flags report whether the gate-drive supply is above the upper and the lower undervoltage thresholds. A zero-crossing flag reports when the inductor current reaches zero.

Every input passes through two flip-flops before it is decoded. The controller filters the mid-window level on each control pin with its own entry hold-off and exit latency. From the filtered levels and the supply state it selects one of five modes:
- Disabled
- discontinuous conduction (DCM)
- forced continuous conduction (FCCM)
- light quiescent (LQ)
- ultra-light quiescent (ULQ)

It then drives the high-side and low-side gate enables with dead time and a minimum high-side on-time. The bootstrap switch enable follows the low-side gate. Every delay is a parameter counted in cycles of one system clock; the defaults assume 100 MHz.

Top module: `buck_gate_mode_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (Disabled) and hs_en_o, ls_en_o and boot_en_o are all 0. The mode codes are 0 Disabled, 1 DCM, 2 FCCM, 3 LQ and 4 ULQ.
- R2: The undervoltage state is set by reset. It clears when vdd_hi_ok_i has been 1 and sets again when vdd_lo_ok_i is 0. A change on either flag is visible on mode_o 4 cycles later. While the state is set, mode_o is 0, both gates are 0, and PWM activity has no effect.
- R3: In an active mode (DCM or FCCM), a PWM high level (pwm_hi_i=1, pwm_lo_i=0) turns the high-side gate on. A PWM low level (pwm_hi_i=0, pwm_lo_i=1) turns the low-side gate on. After a PWM low-to-high step, ls_en_o falls 4 cycles after the input change.
- R4: hs_en_o and ls_en_o are never 1 in the same cycle. When one gate hands over directly to the other, both gates are off for exactly DEAD_CYC+1 cycles.
- R5: In FCCM, take a PWM high pulse of P cycles that follows a long low-side interval. The high-side gate then stays on for max(MIN_ON_CYC, P-DEAD_CYC-1) cycles, so even a 1-cycle pulse gives a full minimum-width high-side pulse.
- R6: With SKIP low (mode 1), a zero-crossing flag seen during the PWM low phase turns the low-side gate off 4 cycles after zx_i rises. The gate then stays off until the next PWM high, even if zx_i falls again.
- R7: With SKIP high (mode 2), zx_i is ignored and the low-side gate stays on for the whole PWM low phase.
- R8: A PWM mid-window level lasting fewer than PWM_HOLD_CYC cycles changes nothing. A PWM mid-window level that lasts longer moves mode_o to 3 (LQ) and both gates off, PWM_HOLD_CYC+3 cycles after the input change. This holds whether the pin was high or low before.
- R9: When PWM leaves the mid window, the new level takes effect on mode_o PWM_EXIT_CYC+3 cycles after the input change. The mode is then 2 (FCCM) for exactly CCM_HOLD_CYC cycles whatever SKIP is, and zx_i is ignored during that window.
- R10: A SKIP mid-window level held for SKIP_HOLD_CYC cycles moves mode_o to 4 (ULQ) SKIP_HOLD_CYC+3 cycles after the input change, with both gates off. ULQ takes priority over LQ. In ULQ the undervoltage state is frozen, so changes on the supply flags have no effect.
- R11: Pulling SKIP low from ULQ makes mode_o leave ULQ SKIP_EXIT_CYC+3 cycles after the input change. The default SKIP_EXIT_CYC is 2000 cycles, which is 20 us at 100 MHz and so within 50 us.
- R12: boot_en_o equals ls_en_o in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_hi_i | input | 1 | PWM pin above high threshold |
| pwm_lo_i | input | 1 | PWM pin below low threshold |
| skip_hi_i | input | 1 | SKIP pin above high threshold |
| skip_lo_i | input | 1 | SKIP pin below low threshold |
| vdd_hi_ok_i | input | 1 | Gate supply above upper lockout threshold |
| vdd_lo_ok_i | input | 1 | Gate supply above lower lockout threshold |
| zx_i | input | 1 | Inductor current zero-crossing flag |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| boot_en_o | output | 1 | Bootstrap switch enable |
| mode_o | output | 3 | Current mode code (see R1) |

## Verification
Some rules are checked by the assertions on every cycle:
- the two gates never overlap, and the high-side gate never rises straight out of low-side conduction;
- Disabled, LQ and ULQ always keep both gates off;
- the undervoltage state stays frozen across ULQ cycles;
- a filtered level enters the mid window only after a raw mid sample.

The exact cycle counts can only be shown by the bench's scenarios. These are the hold-off and exit latencies, the length of the forced-continuous window, the dead-time gap and the minimum on-time widths over a sweep of pulse lengths, and the point at which the zero-crossing cut-off takes effect.

// File: rtl/buck_gate_pkg.sv
package buck_gate_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_MID  = 2'd2
  } pin_lvl_e;

  typedef enum logic [2:0] {
    MODE_OFF  = 3'd0,
    MODE_DCM  = 3'd1,
    MODE_FCCM = 3'd2,
    MODE_LQ   = 3'd3,
    MODE_ULQ  = 3'd4
  } drv_mode_e;

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;

endmodule

// File: rtl/tri_level_filter.sv
module tri_level_filter
  import buck_gate_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 6,
  parameter int unsigned EXIT_CYC = 10
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hi_i,
  input  logic     lo_i,
  output pin_lvl_e lvl_o,
  output logic     exit_o
);

  localparam int unsigned CNT_MAX = (HOLD_CYC > EXIT_CYC) ? HOLD_CYC : EXIT_CYC;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);

  pin_lvl_e        raw;
  pin_lvl_e        lvl_q;
  logic [CW-1:0]   cnt_q;
  logic            exit_q;

  always_comb begin
    if (hi_i && !lo_i)      raw = LVL_HIGH;
    else if (lo_i && !hi_i) raw = LVL_LOW;
    else                    raw = LVL_MID;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= LVL_LOW;
      cnt_q  <= '0;
      exit_q <= 1'b0;
    end else begin
      exit_q <= 1'b0;
      if (lvl_q != LVL_MID) begin
        if (raw == LVL_MID) begin
          if (cnt_q == CW'(HOLD_CYC - 1)) begin
            lvl_q <= LVL_MID;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          lvl_q <= raw;
          cnt_q <= '0;
        end
      end else begin
        if (raw != LVL_MID) begin
          if (cnt_q == CW'(EXIT_CYC - 1)) begin
            lvl_q  <= raw;
            cnt_q  <= '0;
            exit_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end

  assign lvl_o  = lvl_q;
  assign exit_o = exit_q;

  // R8
  mid_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q == LVL_MID && $past(lvl_q) != LVL_MID) |-> $past(raw) == LVL_MID);

endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer #(
  parameter int unsigned DEAD_CYC   = 2,
  parameter int unsigned MIN_ON_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kill_i,
  input  logic hs_req_i,
  input  logic ls_req_i,
  output logic hs_o,
  output logic ls_o
);

  localparam int unsigned DW = $clog2(DEAD_CYC + 1);
  localparam int unsigned MW = $clog2(MIN_ON_CYC + 1);

  logic          hs_q, ls_q;
  logic          hs_req_q;
  logic          armed_q;
  logic [DW-1:0] dead_q;
  logic [MW-1:0] mon_q;
  logic          hs_rise;

  assign hs_rise = hs_req_i && !hs_req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q     <= 1'b0;
      ls_q     <= 1'b0;
      hs_req_q <= 1'b0;
      armed_q  <= 1'b0;
      dead_q   <= '0;
      mon_q    <= '0;
    end else begin
      hs_req_q <= hs_req_i;
      armed_q  <= armed_q | hs_rise;
      if (kill_i) begin
        hs_q    <= 1'b0;
        ls_q    <= 1'b0;
        armed_q <= 1'b0;
        mon_q   <= '0;
        if (hs_q || ls_q)      dead_q <= DW'(DEAD_CYC);
        else if (dead_q != '0) dead_q <= dead_q - 1'b1;
      end else if (hs_q) begin
        if (!hs_req_i && mon_q == '0) begin
          hs_q   <= 1'b0;
          dead_q <= DW'(DEAD_CYC);
        end else if (mon_q != '0) begin
          mon_q <= mon_q - 1'b1;
        end
      end else if (ls_q) begin
        if (!ls_req_i) begin
          ls_q   <= 1'b0;
          dead_q <= DW'(DEAD_CYC);
        end
      end else if (dead_q != '0) begin
        dead_q <= dead_q - 1'b1;
      end else if (hs_req_i || armed_q) begin
        // pending high-side request survives the dead window
        hs_q    <= 1'b1;
        mon_q   <= MW'(MIN_ON_CYC - 1);
        armed_q <= 1'b0;
      end else if (ls_req_i) begin
        ls_q <= 1'b1;
      end
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

  // R4
  gate_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_q && ls_q));

  // R4
  hs_after_ls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_q) |-> !$past(ls_q));

  // R4
  ls_after_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_q) |-> !$past(hs_q));

endmodule

// File: rtl/buck_gate_mode_ctrl.sv
module buck_gate_mode_ctrl
  import buck_gate_pkg::*;
#(
  parameter int unsigned DEAD_CYC      = 2,
  parameter int unsigned MIN_ON_CYC    = 4,
  parameter int unsigned PWM_HOLD_CYC  = 6,
  parameter int unsigned PWM_EXIT_CYC  = 10,
  parameter int unsigned SKIP_HOLD_CYC = 100,
  parameter int unsigned SKIP_EXIT_CYC = 2000,
  parameter int unsigned CCM_HOLD_CYC  = 400
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwm_hi_i,
  input  logic       pwm_lo_i,
  input  logic       skip_hi_i,
  input  logic       skip_lo_i,
  input  logic       vdd_hi_ok_i,
  input  logic       vdd_lo_ok_i,
  input  logic       zx_i,
  output logic       hs_en_o,
  output logic       ls_en_o,
  output logic       boot_en_o,
  output logic [2:0] mode_o
);

  localparam int unsigned NSYNC = 7;
  localparam int unsigned CCW   = $clog2(CCM_HOLD_CYC + 1);

  logic [NSYNC-1:0] raw_flags, sync_flags;
  logic pwm_hi_s, pwm_lo_s, skip_hi_s, skip_lo_s, vhi_s, vlo_s, zx_s;

  assign raw_flags = {pwm_hi_i, pwm_lo_i, skip_hi_i, skip_lo_i, vdd_hi_ok_i, vdd_lo_ok_i, zx_i};
  assign {pwm_hi_s, pwm_lo_s, skip_hi_s, skip_lo_s, vhi_s, vlo_s, zx_s} = sync_flags;

  flag_sync #(.WIDTH(NSYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_flags),
    .q_o   (sync_flags)
  );

  pin_lvl_e pwm_lvl, skip_lvl;
  logic     pwm_exit, skip_exit;

  tri_level_filter #(.HOLD_CYC(PWM_HOLD_CYC), .EXIT_CYC(PWM_EXIT_CYC)) u_pwm_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hi_i  (pwm_hi_s),
    .lo_i  (pwm_lo_s),
    .lvl_o (pwm_lvl),
    .exit_o(pwm_exit)
  );

  tri_level_filter #(.HOLD_CYC(SKIP_HOLD_CYC), .EXIT_CYC(SKIP_EXIT_CYC)) u_skip_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hi_i  (skip_hi_s),
    .lo_i  (skip_lo_s),
    .lvl_o (skip_lvl),
    .exit_o(skip_exit)
  );

  drv_mode_e      mode_d, mode_q;
  logic           uvlo_q;
  logic [CCW-1:0] ccm_q;
  logic           zx_cut_q;
  logic           active, hs_cmd, ls_cmd;

  // lockout with hysteresis, frozen while in ULQ
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             uvlo_q <= 1'b1;
    else if (mode_q != MODE_ULQ) begin
      if (uvlo_q && vhi_s)                   uvlo_q <= 1'b0;
      else if (!uvlo_q && !vlo_s)            uvlo_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ccm_q <= '0;
    else if (pwm_exit)      ccm_q <= CCW'(CCM_HOLD_CYC - 1);
    else if (ccm_q != '0)   ccm_q <= ccm_q - 1'b1;
  end

  always_comb begin
    if (uvlo_q)                                          mode_d = MODE_OFF;
    else if (skip_lvl == LVL_MID)                        mode_d = MODE_ULQ;
    else if (pwm_lvl == LVL_MID)                         mode_d = MODE_LQ;
    else if (pwm_exit || ccm_q != '0 || skip_lvl == LVL_HIGH) mode_d = MODE_FCCM;
    else                                                 mode_d = MODE_DCM;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_OFF;
    else         mode_q <= mode_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                                     zx_cut_q <= 1'b0;
    else if (mode_d != MODE_DCM || pwm_lvl == LVL_HIGH || skip_exit) zx_cut_q <= 1'b0;
    else if (zx_s && pwm_lvl == LVL_LOW)                             zx_cut_q <= 1'b1;
  end

  assign active = (mode_d == MODE_DCM) || (mode_d == MODE_FCCM);
  assign hs_cmd = active && (pwm_lvl == LVL_HIGH);
  assign ls_cmd = active && !hs_cmd && !((mode_d == MODE_DCM) && zx_cut_q);

  gate_sequencer #(.DEAD_CYC(DEAD_CYC), .MIN_ON_CYC(MIN_ON_CYC)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kill_i  (!active),
    .hs_req_i(hs_cmd),
    .ls_req_i(ls_cmd),
    .hs_o    (hs_en_o),
    .ls_o    (ls_en_o)
  );

  assign boot_en_o = ls_en_o;
  assign mode_o    = mode_q;

  // R2
  off_gates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_OFF) |-> (!hs_en_o && !ls_en_o));

  // R8 R10
  quiet_gates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_LQ || mode_q == MODE_ULQ) |-> (!hs_en_o && !ls_en_o));

  // R10
  ulq_uvlo_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q) == MODE_ULQ) |-> $stable(uvlo_q));

endmodule

// File: tb/buck_gate_mode_ctrl_tb.sv
module buck_gate_mode_ctrl_tb;

  localparam int DEAD = 2, MINON = 4, PH = 6, PE = 10, SH = 12, SE = 20, CCM = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwm_hi = 1'b0, pwm_lo = 1'b1, skip_hi = 1'b1, skip_lo = 1'b0;
  logic vhi = 1'b0, vlo = 1'b0, zx = 1'b0;
  logic hs, ls, boot;
  logic [2:0] mode;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  buck_gate_mode_ctrl #(
    .DEAD_CYC(DEAD), .MIN_ON_CYC(MINON), .PWM_HOLD_CYC(PH), .PWM_EXIT_CYC(PE),
    .SKIP_HOLD_CYC(SH), .SKIP_EXIT_CYC(SE), .CCM_HOLD_CYC(CCM)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwm_hi_i(pwm_hi), .pwm_lo_i(pwm_lo),
    .skip_hi_i(skip_hi), .skip_lo_i(skip_lo), .vdd_hi_ok_i(vhi), .vdd_lo_ok_i(vlo),
    .zx_i(zx), .hs_en_o(hs), .ls_en_o(ls), .boot_en_o(boot), .mode_o(mode)
  );

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  // 0 low, 1 high, 2 mid
  task automatic set_pwm(input int v);
    pwm_hi = (v == 1);
    pwm_lo = (v == 0);
  endtask

  task automatic set_skip(input int v);
    skip_hi = (v == 1);
    skip_lo = (v == 0);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R4 R12 on every sampled cycle
  always @(negedge clk) if (rst_n && !done) begin
    chk("R4 overlap", int'(hs && ls), 0);
    chk("R12 boot", int'(boot), int'(ls));
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 run hung: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int hs_w, gap_pre, gap_post, first_ls0, fccm_n, ls_bad;
    bit seen;
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1
    chk("R1 mode", int'(mode), 0);
    chk("R1 hs", int'(hs), 0);
    chk("R1 ls", int'(ls), 0);
    chk("R1 boot", int'(boot), 0);

    // R2: lower flag alone does not release; PWM ignored
    vlo = 1'b1;
    for (int i = 0; i < 12; i++) begin
      set_pwm(i % 2);
      step(1);
      chk("R2 gates in lockout", int'(hs || ls), 0);
    end
    set_pwm(0);
    chk("R2 still off", int'(mode), 0);
    vhi = 1'b1;
    step(3);
    chk("R2 release n3", int'(mode), 0);
    step(1);
    chk("R2 release n4", int'(mode), 2);
    chk("R3 ls on in FCCM low", int'(ls), 1);
    vhi = 1'b0;
    step(10);
    chk("R2 hysteresis", int'(mode), 2);

    // R3 R4 R5: pulse width sweep in FCCM
    for (int p = 1; p <= 12; p++) begin
      step(20);
      set_pwm(1);
      hs_w = 0; gap_pre = 0; gap_post = 0; first_ls0 = 0; seen = 0;
      for (int k = 1; k <= 40; k++) begin
        @(negedge clk);
        if (!ls && first_ls0 == 0) first_ls0 = k;
        if (hs) begin hs_w++; seen = 1; end
        else if (!ls && !seen) gap_pre++;
        else if (!ls && seen && (k < 40)) gap_post++;
        if (k == p) set_pwm(0);
      end
      chk($sformatf("R3 ls fall latency p%0d", p), first_ls0, 4);
      chk($sformatf("R5 hs width p%0d", p), hs_w, (MINON > p - DEAD - 1) ? MINON : p - DEAD - 1);
      chk($sformatf("R4 gap before hs p%0d", p), gap_pre, DEAD + 1);
      chk($sformatf("R4 gap after hs p%0d", p), gap_post, DEAD + 1);
      chk($sformatf("R3 ls back p%0d", p), int'(ls), 1);
    end

    // R7: FCCM ignores zero crossing
    zx = 1'b1;
    set_pwm(1); step(8); set_pwm(0);
    step(30);
    chk("R7 ls stays on", int'(ls), 1);
    zx = 1'b0;

    // R6: DCM zero-crossing cut-off
    set_skip(0);
    step(10);
    chk("R6 mode DCM", int'(mode), 1);
    set_pwm(1); step(8); set_pwm(0);
    step(20);
    chk("R6 ls on before zx", int'(ls), 1);
    zx = 1'b1;
    step(3);
    chk("R6 ls n3", int'(ls), 1);
    step(1);
    chk("R6 ls n4", int'(ls), 0);
    zx = 1'b0;
    step(10);
    chk("R6 ls stays off", int'(ls), 0);
    chk("R6 hs off", int'(hs), 0);
    set_pwm(1);
    hs_w = 0;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (hs) hs_w++;
      if (k == 8) set_pwm(0);
    end
    chk("R6 hs width from idle", hs_w, 8);
    chk("R6 ls resumes", int'(ls), 1);

    // R8: short mid ignored, long mid enters LQ (from low)
    set_pwm(2);
    ls_bad = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (k == PH - 1) set_pwm(0);
      if (!ls || mode != 3'd1) ls_bad++;
    end
    chk("R8 short mid ignored", ls_bad, 0);
    set_pwm(2);
    step(PH + 2);
    chk("R8 before hold", int'(mode), 1);
    step(1);
    chk("R8 LQ from low", int'(mode), 3);
    chk("R8 gates off", int'(hs || ls), 0);

    // R8 from high
    set_pwm(1);
    step(60);
    chk("R8 hs on high", int'(hs), 1);
    set_pwm(2);
    step(PH + 2);
    chk("R8 hs held in hold-off", int'(hs), 1);
    step(1);
    chk("R8 LQ from high", int'(mode), 3);
    chk("R8 hs off", int'(hs), 0);

    // R9: exit latency and forced continuous window
    zx = 1'b1;
    set_pwm(0);
    step(PE + 2);
    chk("R9 before exit", int'(mode), 3);
    fccm_n = 0; ls_bad = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (mode == 3'd2) begin
        fccm_n++;
        if (!ls) ls_bad++;
      end
      if (k == 0) chk("R9 exit mode", int'(mode), 2);
    end
    chk("R9 window length", fccm_n, CCM);
    chk("R9 zx ignored in window", ls_bad, 0);
    chk("R9 DCM after window", int'(mode), 1);
    chk("R9 zx acts after window", int'(ls), 0);
    zx = 1'b0;

    // R10: LQ then ULQ priority, lockout frozen
    set_pwm(2);
    step(20);
    chk("R10 LQ first", int'(mode), 3);
    set_skip(2);
    step(SH + 2);
    chk("R10 before skip hold", int'(mode), 3);
    step(1);
    chk("R10 ULQ", int'(mode), 4);
    vhi = 1'b0; vlo = 1'b0;
    step(10);
    chk("R10 supply ignored", int'(mode), 4);
    vlo = 1'b1;
    set_pwm(0);
    step(60);
    chk("R10 ULQ kept", int'(mode), 4);
    chk("R10 gates off", int'(hs || ls), 0);

    // R11: wake by SKIP low
    set_skip(0);
    step(SE + 2);
    chk("R11 before exit", int'(mode), 4);
    step(1);
    chk("R11 wake DCM", int'(mode), 1);
    chk("R11 ls on", int'(ls), 1);

    // R2: falling below lower threshold
    vlo = 1'b0;
    step(3);
    chk("R2 fall n3", int'(mode), 1);
    step(1);
    chk("R2 fall n4", int'(mode), 0);
    chk("R2 gates off", int'(hs || ls), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule